// File: doc/BRIEF.md
# Two-Bank Flash Program and Erase Controller

This block sits between a simple word bus and a behavioural model of an embedded flash array split into two independent banks. Array words are read directly over the bus. They can never be written directly. Software changes them only through commanded operations. To program, it loads a word buffer and writes a transaction register with a word offset and a zero-based word count. It then arms the controller with an enable key and writes an opcode to the control register of the target bank. Erase uses the same sequence and clears one whole page.

An operation occupies its bank for a fixed, parameterised number of cycles. During that time every array access to that bank is stalled by holding the ready output low. The other bank stays fully accessible. Requests that are malformed, unarmed or out of range leave the array untouched and set a bit in an error register. That register clears itself once it has been read.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset every array word reads 0xFFFFFFFF, the error register and both control registers read zero, and an array read completes with no stall.
- R2: An erase (control value 0x31415927) sets all PAGE_WORDS words of the page holding the transaction offset to 0xFFFFFFFF in the addressed bank. Other pages and the other bank keep their contents.
- R3: A program (control value 0x27182818) replaces each of the words offset..offset+N of the addressed bank with the old value ANDed with buffer entry 0..N. Here N is the count field, bits [16 +: log2(BUF_WORDS)] of the transaction register, and the offset is bits [15:0].
- R4: A control write accepted while the controller is not armed by a prior write of 0xB11924E1 to the key register (word 1) starts nothing and sets error bit 0.
- R5: Any control write to either bank disarms the key, so a following control write without a new key write starts nothing.
- R6: A control value other than the two opcodes starts nothing and sets error bit 1.
- R7: After a start, the bank's control register (word 2 for bank 0, word 3 for bank 1) reads back the opcode for OP_CYCLES cycles and then reads zero.
- R8: While a bank is busy, an array read to it holds ready low until the operation ends, exactly OP_CYCLES cycles after the start. Array reads to the other bank are not stalled.
- R9: An erase whose offset lies beyond the bank, or a program whose last word would lie beyond the bank, starts nothing, sets error bit 2 and leaves the array unchanged.
- R10: A read of the error register (word 4) returns its bits and clears them, so an immediate second read returns zero.
- R11: A control write to a bank that is still busy starts nothing and sets error bit 3.
- R12: A control write while transaction bit 31 (the info-area select) is set starts nothing and sets error bit 4.
- R13: A bus write into array space has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Bus request valid |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_regsel | input | 1 | 1 selects register space, 0 selects array space |
| cpu_addr | input | AW | Word address: {bank, word} in array space, register word in register space (buffer at BUF_WORDS+i) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when ready is high |
| cpu_ready | output | 1 | Low while an array access targets a busy bank |

## Verification
The bench builds the controller with PAGES=4, PAGE_WORDS=8, BUF_WORDS=16 and OP_CYCLES=12. Each bank is then only 32 words, so the whole array is compared against a reference after every table operation. These sizes also make the cases at the bank's last word reachable: a program that ends exactly at the boundary, and one that would run past it. A short OP_CYCLES lets the bench count the exact stall length. It also lets it issue a colliding control write while the bank is still busy.

// File: rtl/flash_pe_ctrl.sv
`timescale 1ns/1ps
module flash_pe_ctrl #(
  parameter int PAGES      = 8,
  parameter int PAGE_WORDS = 16,
  parameter int BUF_WORDS  = 32,
  parameter int OP_CYCLES  = 20,
  localparam int BANK_WORDS = PAGES * PAGE_WORDS,
  localparam int FAW        = $clog2(BANK_WORDS) + 1,
  localparam int RAW        = $clog2(BUF_WORDS) + 1,
  localparam int AW         = (FAW > RAW) ? FAW : RAW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_regsel,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic          cpu_ready
);
  localparam int CW  = $clog2(BUF_WORDS);
  localparam int CTW = $clog2(OP_CYCLES + 1);
  localparam logic [31:0] KEY      = 32'hB119_24E1;
  localparam logic [31:0] OP_ERASE = 32'h3141_5927;
  localparam logic [31:0] OP_PROG  = 32'h2718_2818;
  localparam logic [RAW-1:0] A_TRANS = RAW'(0);
  localparam logic [RAW-1:0] A_KEY   = RAW'(1);
  localparam logic [RAW-1:0] A_CTRL0 = RAW'(2);
  localparam logic [RAW-1:0] A_ERR   = RAW'(4);

  logic [31:0]    mem  [2][BANK_WORDS];
  logic [31:0]    wbuf [BUF_WORDS];
  logic [31:0]    op_q [2];
  logic [CTW-1:0] cnt_q [2];
  logic [31:0]    trans_q;
  logic           armed;
  logic [4:0]     err_q, new_err;
  logic [1:0]     busy, ctrl_wr, start;

  wire [RAW-1:0]   raddr = cpu_addr[RAW-1:0];
  wire             fbank = cpu_addr[FAW-1];
  wire [FAW-2:0]   fword = cpu_addr[FAW-2:0];
  wire [15:0]      off   = trans_q[15:0];
  wire [CW-1:0]    cm1   = trans_q[16 +: CW];
  wire             info  = trans_q[31];
  wire             is_erase = (cpu_wdata == OP_ERASE);
  wire             op_ok    = is_erase || (cpu_wdata == OP_PROG);
  wire             range_bad = is_erase ? (int'(off) >= BANK_WORDS)
                                        : (int'(off) + int'(cm1) + 1 > BANK_WORDS);

  assign busy[0]   = cnt_q[0] != '0;
  assign busy[1]   = cnt_q[1] != '0;
  assign cpu_ready = !(cpu_req && !cpu_regsel && busy[fbank]);

  wire acc    = cpu_req && cpu_ready;
  wire wr     = acc && cpu_we && cpu_regsel;
  wire err_rd = acc && !cpu_we && cpu_regsel && !raddr[CW] && raddr == A_ERR;

  always_comb begin
    for (int b = 0; b < 2; b++)
      ctrl_wr[b] = wr && !raddr[CW] && raddr == A_CTRL0 + RAW'(b);
    new_err = '0;
    if (ctrl_wr != '0) begin
      new_err[0] = !armed;
      new_err[1] = !op_ok;
      new_err[2] = op_ok && range_bad;
      new_err[3] = busy[ctrl_wr[1]];
      new_err[4] = info;
    end
    for (int b = 0; b < 2; b++)
      start[b] = ctrl_wr[b] && new_err == '0;
  end

  always_comb begin
    cpu_rdata = '0;
    if (!cpu_regsel)
      cpu_rdata = mem[fbank][fword];
    else if (raddr[CW])
      cpu_rdata = wbuf[raddr[CW-1:0]];
    else if (raddr == A_TRANS)
      cpu_rdata = trans_q;
    else if (raddr == A_CTRL0)
      cpu_rdata = busy[0] ? op_q[0] : '0;
    else if (raddr == A_CTRL0 + RAW'(1))
      cpu_rdata = busy[1] ? op_q[1] : '0;
    else if (raddr == A_ERR)
      cpu_rdata = {27'b0, err_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trans_q <= '0;
      armed   <= 1'b0;
      err_q   <= '0;
      for (int b = 0; b < 2; b++) begin
        op_q[b]  <= '0;
        cnt_q[b] <= '0;
      end
      for (int i = 0; i < BUF_WORDS; i++) wbuf[i] <= '0;
    end else begin
      if (wr && !raddr[CW] && raddr == A_TRANS) trans_q <= cpu_wdata;
      if (wr && !raddr[CW] && raddr == A_KEY)   armed   <= (cpu_wdata == KEY);
      if (ctrl_wr != '0)                         armed   <= 1'b0;
      if (wr && raddr[CW]) wbuf[raddr[CW-1:0]] <= cpu_wdata;
      err_q <= (err_rd ? 5'b0 : err_q) | new_err;
      for (int b = 0; b < 2; b++) begin
        if (start[b]) begin
          cnt_q[b] <= CTW'(OP_CYCLES);
          op_q[b]  <= cpu_wdata;
        end else if (busy[b]) begin
          cnt_q[b] <= cnt_q[b] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < BANK_WORDS; w++) mem[b][w] <= '1;
    end else begin
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < BANK_WORDS; w++)
          if (start[b]) begin
            if (is_erase) begin
              if (w / PAGE_WORDS == int'(off) / PAGE_WORDS) mem[b][w] <= '1;
            end else if (w >= int'(off) && w <= int'(off) + int'(cm1)) begin
              mem[b][w] <= mem[b][w] & wbuf[CW'(w - int'(off))];
            end
          end
    end
  end
endmodule

// File: rtl/flash_pe_ctrl_chk.sv
`timescale 1ns/1ps
module flash_pe_ctrl_chk #(
  parameter int FAW = 9,
  parameter int RAW = 6,
  parameter int AW  = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_regsel,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_ready,
  input logic [1:0]    busy,
  input logic [1:0]    ctrl_wr,
  input logic          armed,
  input logic [4:0]    err_q
);
  p_stall_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_regsel && busy[cpu_addr[FAW-1]] |-> !cpu_ready);

  p_start_armed0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[0]) |-> $past(armed) && $past(ctrl_wr[0]));

  p_start_armed1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[1]) |-> $past(armed) && $past(ctrl_wr[1]));

  p_key_spent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr != 2'b00 |=> !armed);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ready && !cpu_we && cpu_regsel && cpu_addr[RAW-1:0] == RAW'(4)
      |=> err_q == 5'b0);

  p_busy_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy[0] && ctrl_wr[0]) || (busy[1] && ctrl_wr[1]) |=> err_q[3]);

  p_one_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_wr));
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.FAW(FAW), .RAW(RAW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_regsel(cpu_regsel), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
  .busy(busy), .ctrl_wr(ctrl_wr), .armed(armed), .err_q(err_q));

// File: tb/flash_pe_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_pe_ctrl_tb_top;
  localparam int PG = 4, PW = 8, BUFW = 16, OPC = 12;
  localparam int BANK = PG * PW;
  localparam logic [31:0] KEY = 32'hB119_24E1, OPE = 32'h3141_5927, OPP = 32'h2718_2818;
  localparam logic [5:0] R_TRANS = 6'd0, R_KEY = 6'd1, R_CTRL0 = 6'd2, R_ERR = 6'd4;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, cpu_regsel = 0;
  logic [5:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready;
  int n_chk = 0, n_bad = 0;
  logic [31:0] model [2][BANK];
  logic [31:0] bufm [BUFW];

  always #2.5 clk = ~clk;

  flash_pe_ctrl #(.PAGES(PG), .PAGE_WORDS(PW), .BUF_WORDS(BUFW), .OP_CYCLES(OPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_regsel(cpu_regsel),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready));

  typedef struct packed { logic er; logic bk; logic [4:0] off; logic [3:0] cm1; logic [31:0] seed; } vec_t;
  localparam vec_t VEC [7] = '{
    {1'b0, 1'b0, 5'd0,  4'd15, 32'hA5A5_F00F},
    {1'b0, 1'b0, 5'd3,  4'd4,  32'h0FF0_FFFF},
    {1'b1, 1'b0, 5'd9,  4'd0,  32'h0},
    {1'b0, 1'b1, 5'd31, 4'd0,  32'h1234_5678},
    {1'b0, 1'b1, 5'd16, 4'd15, 32'hFFFF_0000},
    {1'b1, 1'b1, 5'd31, 4'd3,  32'h0},
    {1'b0, 1'b0, 5'd8,  4'd7,  32'h3C3C_3C3C}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic rs, input logic we, input logic [5:0] a, input logic [31:0] d,
                     output logic [31:0] q, output int stalls);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_regsel = rs; cpu_addr = a; cpu_wdata = d;
    #1; stalls = 0;
    while (!cpu_ready) begin @(negedge clk); #1; stalls++; end
    q = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] q; int s;
    bus(1, 1, a, d, q, s);
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] q);
    int s;
    bus(1, 0, a, '0, q, s);
  endtask

  task automatic rd_fl(input logic bk, input int w, output logic [31:0] q, output int s);
    bus(0, 0, {bk, 5'(w)}, '0, q, s);
  endtask

  task automatic launch(input logic er, input logic bk, input int off, input int cm1,
                        input logic inf, input logic key);
    wr_reg(R_TRANS, {inf, 7'b0, 8'(cm1), 16'(off)});
    if (key) wr_reg(R_KEY, KEY);
    wr_reg(R_CTRL0 + 6'(bk), er ? OPE : OPP);
  endtask

  task automatic wait_idle(input logic bk);
    logic [31:0] q;
    for (int i = 0; i < 4 * OPC; i++) begin
      rd_reg(R_CTRL0 + 6'(bk), q);
      if (q == 0) break;
    end
  endtask

  task automatic model_apply(input logic er, input logic bk, input int off, input int cm1);
    for (int w = 0; w < BANK; w++)
      if (er) begin
        if (w / PW == off / PW) model[bk][w] = '1;
      end else if (w >= off && w <= off + cm1) begin
        model[bk][w] = model[bk][w] & bufm[w - off];
      end
  endtask

  task automatic cmp_all(input string tag);
    logic [31:0] q; int s; int miss = 0;
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < BANK; w++) begin
        rd_fl(1'(b), w, q, s);
        if (q !== model[b][w]) begin
          if (miss == 0) $display("FAIL %s bank=%0d word=%0d actual=%h expected=%h",
                                  tag, b, w, q, model[b][w]);
          miss++;
        end
      end
    n_chk++;
    if (miss != 0) n_bad++;
  endtask

  initial begin
    #(5 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] q; int s;
    for (int b = 0; b < 2; b++) for (int w = 0; w < BANK; w++) model[b][w] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_reg(R_ERR, q);             check("R1 error reg", q, 0);
    rd_reg(R_CTRL0, q);           check("R1 ctrl0", q, 0);
    rd_reg(R_CTRL0 + 6'd1, q);    check("R1 ctrl1", q, 0);
    rd_fl(1, 7, q, s);            check("R1 array word", q, 32'hFFFF_FFFF);
    check("R1 no stall", 32'(s), 0);

    // table: R2 erase, R3 program, R7 readback
    foreach (VEC[k]) begin
      for (int i = 0; i < BUFW; i++) begin
        bufm[i] = VEC[k].seed ^ (32'(i) * 32'h0001_0003);
        wr_reg(6'(BUFW + i), bufm[i]);
      end
      launch(VEC[k].er, VEC[k].bk, int'(VEC[k].off), int'(VEC[k].cm1), 0, 1);
      rd_reg(R_CTRL0 + 6'(VEC[k].bk), q);
      check("R7 ctrl readback while busy", q, VEC[k].er ? OPE : OPP);
      wait_idle(VEC[k].bk);
      rd_reg(R_CTRL0 + 6'(VEC[k].bk), q);
      check("R7 ctrl zero after op", q, 0);
      model_apply(VEC[k].er, VEC[k].bk, int'(VEC[k].off), int'(VEC[k].cm1));
      cmp_all(VEC[k].er ? "R2 erase result" : "R3 program result");
      rd_reg(R_ERR, q);           check("R3 no error on valid op", q, 0);
    end

    // R8 stall length on busy bank
    launch(1, 0, 16, 0, 0, 1);
    rd_fl(0, 17, q, s);
    check("R8 stall cycles", 32'(s), OPC);
    check("R2 erased word after stall", q, 32'hFFFF_FFFF);
    model_apply(1, 0, 16, 0);

    // R8 other bank free, R11 busy collision
    launch(1, 1, 0, 0, 0, 1);
    rd_fl(0, 0, q, s);
    check("R8 other bank no stall", 32'(s), 0);
    check("R8 other bank data", q, model[0][0]);
    wr_reg(R_KEY, KEY);
    wr_reg(R_CTRL0 + 6'd1, OPE);
    rd_reg(R_ERR, q);             check("R11 busy error", q, 32'h8);
    wait_idle(1);
    model_apply(1, 1, 0, 0);
    cmp_all("R11 array after collision");

    // R4 missing key
    bufm[0] = 32'h0; wr_reg(6'(BUFW), 0);
    launch(0, 0, 2, 0, 0, 0);
    rd_reg(R_CTRL0, q);           check("R4 no start", q, 0);
    rd_reg(R_ERR, q);             check("R4 key error", q, 32'h1);
    rd_reg(R_ERR, q);             check("R10 error cleared", q, 0);
    rd_fl(0, 2, q, s);            check("R4 array unchanged", q, model[0][2]);

    // R6 bad opcode, R5 key consumed
    wr_reg(R_KEY, KEY);
    wr_reg(R_CTRL0 + 6'd1, 32'hDEAD_BEEF);
    rd_reg(R_ERR, q);             check("R6 opcode error", q, 32'h2);
    wr_reg(R_CTRL0, OPP);
    rd_reg(R_CTRL0, q);           check("R5 no start after spent key", q, 0);
    rd_reg(R_ERR, q);             check("R5 key error", q, 32'h1);

    // R9 out of range program and erase
    launch(0, 0, 24, 8, 0, 1);
    rd_reg(R_ERR, q);             check("R9 program range error", q, 32'h4);
    launch(1, 1, 40, 0, 0, 1);
    rd_reg(R_ERR, q);             check("R9 erase range error", q, 32'h4);
    rd_reg(R_CTRL0 + 6'd1, q);    check("R9 no start", q, 0);

    // R12 info select
    launch(1, 0, 0, 0, 1, 1);
    rd_reg(R_ERR, q);             check("R12 info error", q, 32'h10);

    // R13 direct array write
    bus(0, 1, {1'b1, 5'd20}, 32'h0, q, s);
    cmp_all("R9 R12 R13 array unchanged");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule